// File: doc/BRIEF.md
# Dual-Edge Input Glitch Filter

This block sits between the pads of a 32-line general-purpose I/O controller and the logic that reads them back. It samples each pad on both the rising and the falling edge of the controller clock. It lets a level change through to the filtered value only once two consecutive half-cycle samples agree on it. A pulse that lasts half a clock period or less can never appear in two consecutive samples, so it is always removed. A pulse longer than one clock period always shows up in at least one agreeing pair, so it always passes.

Software chooses filtering per line through a filter-select status word. A set word and a clear word write that status: each bit written as 1 sets or clears the matching status bit. For each line, the status bit picks either the filtered value or the plain rising-edge sample. The pin-data readback and the change detector both use that selected value. The peripheral-side copy of each pad bypasses the filter completely. A sample-enable input, which stands for the controller clock being on, freezes every sampler while it is low.

Top module: `gf_input_filter`

## Requirements
- R1: After reset, the filter-select status word reads 0 and the pin-data readback reads 0 on every line.
- R2: A write of the set word (`sel_set_we` high for one cycle) sets each status bit whose `sel_set_val` bit is 1 at the next rising edge. Status bits whose set bit is 0 keep their value.
- R3: A write of the clear word clears each status bit whose `sel_clr_val` bit is 1 at the next rising edge. When both words are written in the same cycle and name the same bit, the clear wins.
- R4: On a line whose status bit is 0, the readback shows the pad level sampled at the most recent rising edge. A pad change therefore appears after the first rising edge that follows it.
- R5: On a line whose status bit is 1, a pad change that settles before a falling edge appears at the following rising edge. This is the same cycle as an unfiltered line.
- R6: On a line whose status bit is 1, a pad change that settles just after a falling edge, and so before a rising edge, appears one clock cycle later than on an unfiltered line.
- R7: On a filtered line, a pulse of half a clock period or less never changes the readback. This holds whether the pulse covers a falling edge or a rising edge.
- R8: On a filtered line, a pulse longer than one clock period always reaches the readback. This holds whether the pulse first covers a falling edge or a rising edge.
- R9: The peripheral output equals the pad input at all times, whatever the status word holds.
- R10: While `smp_en` is low, no sampler updates and the readback holds its value on every line, even if the pads change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| smp_en | input | 1 | Sample enable; high while the controller clock is running |
| pad_i | input | NLINES | Pad levels, already synchronized |
| sel_set_we | input | 1 | Write strobe for the set word |
| sel_set_val | input | NLINES | Set word; each 1 bit sets the status bit |
| sel_clr_we | input | 1 | Write strobe for the clear word |
| sel_clr_val | input | NLINES | Clear word; each 1 bit clears the status bit |
| sel_stat_o | output | NLINES | Filter-select status word |
| pin_data_o | output | NLINES | Per-line readback value, also fed to change detection |
| periph_o | output | NLINES | Unfiltered pad copy for peripherals |

## Verification
Two pairs of functions can act in the same cycle. The set and the clear write can hit the same status bit on one edge. The bench writes both words together with overlapping masks and expects the cleared bit to read 0 while the set-only bit reads 1. Filtered and unfiltered lines also see the same pad edge together. The bench drives one pad pattern to all lines, with alternating lines filtered, and judges every pulse and latency case against two expected words: one for the raw lines and one for the filtered lines.

// File: rtl/gf_pkg.sv
package gf_pkg;

  localparam int unsigned GF_DEF_LINES = 32;

  // New status after one cycle of set/clear writes; clear wins on overlap.
  function automatic logic [GF_DEF_LINES-1:0] gf_apply(
    input logic [GF_DEF_LINES-1:0] cur,
    input logic                    set_we,
    input logic [GF_DEF_LINES-1:0] set_v,
    input logic                    clr_we,
    input logic [GF_DEF_LINES-1:0] clr_v
  );
    logic [GF_DEF_LINES-1:0] s;
    logic [GF_DEF_LINES-1:0] c;
    s = set_we ? set_v : '0;
    c = clr_we ? clr_v : '0;
    return (cur | s) & ~c;
  endfunction

endpackage

// File: rtl/gf_sel_status.sv
module gf_sel_status #(
  parameter int unsigned NLINES = gf_pkg::GF_DEF_LINES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic [NLINES-1:0] set_val,
  input  logic              clr_we,
  input  logic [NLINES-1:0] clr_val,
  output logic [NLINES-1:0] stat_o
);

  localparam int unsigned PADW = gf_pkg::GF_DEF_LINES;

  logic [NLINES-1:0] stat_q;
  logic [NLINES-1:0] stat_d;
  logic [PADW-1:0]   wide_n;
  logic              wr_en;

  assign wr_en = set_we | clr_we;

  always_comb begin
    wide_n = gf_pkg::gf_apply(PADW'(stat_q), set_we, PADW'(set_val),
                              clr_we, PADW'(clr_val));
    stat_d = wr_en ? wide_n[NLINES-1:0] : stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;

  // R2: bits named by a lone set write read 1 afterwards
  a_r2_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !clr_we) |=> ((stat_q & $past(set_val)) == $past(set_val)));

  // R3: bits named by a clear write read 0 afterwards, even with a set
  a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((stat_q & $past(clr_val)) == '0));

  // R2: no write, no change
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(stat_q));

endmodule

// File: rtl/gf_line_filter.sv
module gf_line_filter (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_en,
  input  logic pad,
  output logic raw_o,
  output logic filt_o
);

  // rising-edge sample, falling-edge sample, and agreement flag
  logic raw_q,  raw_d;
  logic filt_q, filt_d;
  logic fall_q, fall_d;
  logic agr_q,  agr_d;

  // falling-edge stage: sample pad, note whether it matches the last rise sample
  always_comb begin
    fall_d = fall_q;
    agr_d  = agr_q;
    if (smp_en) begin
      fall_d = pad;
      agr_d  = (pad == raw_q);
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_q <= 1'b0;
      agr_q  <= 1'b0;
    end else begin
      fall_q <= fall_d;
      agr_q  <= agr_d;
    end
  end

  // rising-edge stage: accept a level seen by two consecutive half-cycle samples
  always_comb begin
    raw_d  = raw_q;
    filt_d = filt_q;
    if (smp_en) begin
      raw_d = pad;
      if (pad == fall_q)  filt_d = pad;
      else if (agr_q)     filt_d = fall_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= 1'b0;
      filt_q <= 1'b0;
    end else begin
      raw_q  <= raw_d;
      filt_q <= filt_d;
    end
  end

  assign raw_o  = raw_q;
  assign filt_o = filt_q;

  // R10: samplers frozen while sampling is disabled
  a_r10_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> ($stable(raw_q) && $stable(filt_q)));

  // R7: a filtered change always matches a rising sample now or one cycle before
  a_r7_agree: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_q) |-> ((filt_q == raw_q) || (filt_q == $past(raw_q))));

endmodule

// File: rtl/gf_input_filter.sv
module gf_input_filter #(
  parameter int unsigned NLINES = gf_pkg::GF_DEF_LINES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_en,
  input  logic [NLINES-1:0] pad_i,
  input  logic              sel_set_we,
  input  logic [NLINES-1:0] sel_set_val,
  input  logic              sel_clr_we,
  input  logic [NLINES-1:0] sel_clr_val,
  output logic [NLINES-1:0] sel_stat_o,
  output logic [NLINES-1:0] pin_data_o,
  output logic [NLINES-1:0] periph_o
);

  logic [NLINES-1:0] sel;
  logic [NLINES-1:0] raw_s;
  logic [NLINES-1:0] filt_s;

  gf_sel_status #(.NLINES(NLINES)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_we  (sel_set_we),
    .set_val (sel_set_val),
    .clr_we  (sel_clr_we),
    .clr_val (sel_clr_val),
    .stat_o  (sel)
  );

  for (genvar gi = 0; gi < NLINES; gi++) begin : g_line
    gf_line_filter u_line (
      .clk    (clk),
      .rst_n  (rst_n),
      .smp_en (smp_en),
      .pad    (pad_i[gi]),
      .raw_o  (raw_s[gi]),
      .filt_o (filt_s[gi])
    );
    assign pin_data_o[gi] = sel[gi] ? filt_s[gi] : raw_s[gi];
  end

  assign sel_stat_o = sel;
  assign periph_o   = pad_i;

  // R4: an unfiltered line follows the pad one rising edge later
  a_r4_raw_path: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && (sel == '0) && $stable(sel)) |=> (pin_data_o == $past(pad_i)));

endmodule

// File: tb/gf_input_filter_bench.sv
module gf_input_filter_bench;

  localparam int unsigned N      = 32;
  localparam time         PERIOD = 10;
  localparam logic [N-1:0] ALL  = '1;
  localparam logic [N-1:0] EVEN = 32'h5555_5555;
  localparam logic [N-1:0] ODD  = 32'hAAAA_AAAA;

  logic         clk;
  logic         rst_n;
  logic         smp_en;
  logic [N-1:0] pad;
  logic         set_we, clr_we;
  logic [N-1:0] set_v, clr_v;
  logic [N-1:0] stat, pin, periph;

  int n_chk  = 0;
  int n_fail = 0;

  gf_input_filter #(.NLINES(N)) u_gf_input_filter (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_en      (smp_en),
    .pad_i       (pad),
    .sel_set_we  (set_we),
    .sel_set_val (set_v),
    .sel_clr_we  (clr_we),
    .sel_clr_val (clr_v),
    .sel_stat_o  (stat),
    .pin_data_o  (pin),
    .periph_o    (periph)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
  endtask

  task automatic wr(input logic sw, input logic [N-1:0] sv, input logic cw, input logic [N-1:0] cv);
    @(posedge clk); #1;
    set_we = sw; set_v = sv; clr_we = cw; clr_v = cv;
    @(posedge clk); #1;
    set_we = 1'b0; clr_we = 1'b0; set_v = '0; clr_v = '0;
  endtask

  task automatic t_reset();
    chk("R1 status", stat, '0);
    chk("R1 readback", pin, '0);
  endtask

  task automatic t_status();
    wr(1'b1, 32'h0000_00F5, 1'b0, '0);
    chk("R2 set", stat, 32'h0000_00F5);
    wr(1'b1, 32'h0000_0F00, 1'b0, '0);
    chk("R2 zeros keep", stat, 32'h0000_0FF5);
    wr(1'b0, '0, 1'b1, 32'h0000_0005);
    chk("R3 clear", stat, 32'h0000_0FF0);
    wr(1'b1, 32'h0000_0003, 1'b1, 32'h0000_0001);
    chk("R3 clear wins", stat, 32'h0000_0FF2);
    wr(1'b0, '0, 1'b1, ALL);
    chk("R3 clear all", stat, '0);
    wr(1'b1, EVEN, 1'b0, '0);
    chk("R2 even lines", stat, EVEN);
  endtask

  task automatic t_before_fall();
    @(posedge clk); #1 pad = ALL;
    #6 chk("R4 before edge", pin, '0);
    @(posedge clk); #2;
    chk("R5 no extra latency", pin, ALL);
    @(posedge clk); #1 pad = '0;
    @(posedge clk); #2;
    chk("R5 return low", pin, '0);
  endtask

  task automatic t_before_rise();
    @(posedge clk); #6 pad = ALL;
    @(posedge clk); #2;
    chk("R4 raw first edge / R6 filtered held", pin, ODD);
    @(posedge clk); #2;
    chk("R6 one cycle later", pin, ALL);
    #4 pad = '0;
    settle(); #2;
    chk("R6 back low", pin, '0);
  endtask

  task automatic t_glitch();
    @(posedge clk); #3 pad = ALL;
    #4 pad = '0;
    @(posedge clk); #2;
    chk("R7 glitch over falling edge", pin, '0);
    @(posedge clk); #2;
    chk("R7 glitch over falling edge later", pin, '0);
    @(posedge clk); #8 pad = ALL;
    #1 chk("R9 peripheral sees glitch", periph, ALL);
    #3 pad = '0;
    chk("R9 peripheral follows pad", periph, '0);
    #0;
    chk("R7 glitch over rising edge, raw lines only", pin, ODD);
    @(posedge clk); #2;
    chk("R7 filtered never moved", pin, '0);
  endtask

  task automatic t_long();
    @(posedge clk); #7 pad = ALL;
    #11 pad = '0;
    @(posedge clk); #2;
    chk("R8 rise-then-fall coverage", pin, EVEN);
    @(posedge clk); #2;
    chk("R8 ends", pin, '0);
    @(posedge clk); #3 pad = ALL;
    @(posedge clk); #2;
    chk("R8 fall-then-rise coverage", pin, ALL);
    #2 pad = '0;
    @(posedge clk); #2;
    chk("R8 ends again", pin, '0);
  endtask

  task automatic t_freeze();
    @(posedge clk); #1 smp_en = 1'b0; pad = ALL;
    settle(); #2;
    chk("R10 held while disabled", pin, '0);
    smp_en = 1'b1;
    settle(); #2;
    chk("R10 resumes", pin, ALL);
    pad = '0;
    settle();
  endtask

  initial begin
    rst_n = 1'b0; smp_en = 1'b1; pad = '0;
    set_we = 1'b0; clr_we = 1'b0; set_v = '0; clr_v = '0;
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_status();
    settle();
    t_before_fall();
    settle();
    t_before_rise();
    settle();
    t_glitch();
    settle();
    t_long();
    settle();
    t_freeze();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule